// File: doc/BRIEF.md
# Multi-Channel Temperature Threshold Monitor

This block watches up to sixteen temperature channels. Each channel delivers a 12-bit two's-complement reading (one step is 0.1 degree) together with a one-cycle strobe. On every accepted reading the block stores the code and compares it against three programmable limits for that channel: a low limit, a high limit and a critical limit. Every comparison is signed. A limit crossing sets a sticky event flag that stays set until software clears it.

Two active-high level interrupts report the events. One covers low and high events and the other covers critical events. An external watchdog-bark strobe also feeds the critical interrupt. Each source has its own mask bit, and each interrupt class has an enable bit. A global enable gates both sampling and the interrupts. Clears act as write pulses: a 1 in a clear word drops the matching flag on that write only. Software re-arms an event by clearing it and unmasking it.

All registers sit on a word-addressed bus. Address bits [7:4] pick a region and bits [3:0] pick the word or the channel. Region 0 holds the global words: 0x00 control, 0x01 interrupt enables, 0x02 low/high clear, 0x03 low/high mask, 0x04 critical clear, 0x05 critical mask and 0x06 critical status. Region 1 holds the channel status words (0x10+n), region 2 the low/high limit words (0x20+n) and region 3 the critical limit words (0x30+n). Reads are combinational. Clear words, unmapped addresses and channels at or above NCH read as 0.

Top module: `tmon_top`

## Requirements
- R1: After reset, the control word (0x00) and the enable word (0x01) read 0. The low/high mask word reads all implemented bits as 1: 0x000F000F for four channels. The critical mask word reads 1 for bit n of every channel and for bits 30 and 31. Every limit word and status word reads 0, and both interrupts are low.
- R2: While bit 0 of the control word is 1, a strobe on channel n stores the code in bits 11:0 of its status word and sets bit 21 (reading seen). While bit 0 is 0, strobes are ignored and the status word does not change.
- R3: An accepted reading whose signed value is less than or equal to the low limit (bits 11:0 of the limit word) sets bit 17 of the status word.
- R4: An accepted reading whose signed value is greater than or equal to the high limit (bits 23:12 of the limit word) sets bit 18 of the status word.
- R5: An accepted reading whose signed value is greater than or equal to the critical limit (bits 11:0 of the critical word) sets bit 19 of the status word. Bit n of the critical status word (0x06) mirrors that flag.
- R6: Event flags are sticky. Later readings that do not meet a condition leave its flag set. Writing 1 to bit n (low) or bit 16+n (high) of word 0x02, or to bit n of word 0x04 (critical), clears that flag. Writing 0 to a clear word changes nothing.
- R7: If a reading that meets a condition is accepted in the same cycle as a clear write for that flag, the flag stays set. If the reading does not meet the condition, the clear takes effect.
- R8: irq_ul is high one cycle after the state that causes it. That state is: control bit 0 is set, and either an unmasked low flag exists with enable bit 0 set, or an unmasked high flag exists with enable bit 1 set. Mask word 0x03 holds the low masks in bits 15:0 and the high masks in bits 31:16. A mask bit of 1 suppresses its source.
- R9: irq_crit is high one cycle after the state that causes it. That state is: control bit 0 is set, enable bit 2 is set, and either a critical flag of channel n exists with bit n of word 0x05 clear, or the bark flag is set with bit 31 of word 0x05 clear.
- R10: A pulse on wd_bark_in sets the bark flag, which reads as bit 31 of word 0x06. Writing 1 to bit 31 of word 0x04 clears it. If a bark pulse and that clear fall in the same cycle, the flag stays set.
- R11: Bit 30 of the critical mask word is a stored control bit. It reads back as written.
- R12: The writable fields read back what was written: control bit 0, enable bits 2:0, mask bits, and the 12-bit limit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_vld | input | NCH | Per-channel reading strobe |
| samp_code | input | NCH*12 | Per-channel reading; channel n occupies bits 12n+11:12n |
| wd_bark_in | input | 1 | Watchdog-bark strobe that sets the bark flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_ul | output | 1 | Low/high event interrupt level |
| irq_crit | output | 1 | Critical and bark interrupt level |

## Verification
A reading that sets a flag and a software clear of that same flag can land in the same cycle. Two cases provoke this on purpose: a reading strobe and a clear write are driven on the same clock edge, once with a code that meets the high and critical limits and once with a code that does not. The status word is then read back. It must show the flag kept in the first case and dropped in the second. The second case must still show the new code and the untouched critical flag. Apart from that, an exhaustive sweep of all 4096 codes, spread over four channels with distinct limits, checks every comparison boundary against values the bench works out itself.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int CODE_W = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Address regions, selected by bus_addr[7:4]
    localparam logic [3:0] RG_GLOBAL = 4'h0;
    localparam logic [3:0] RG_STAT   = 4'h1;
    localparam logic [3:0] RG_THR    = 4'h2;
    localparam logic [3:0] RG_CRIT   = 4'h3;

    // Global word offsets, selected by bus_addr[3:0]
    localparam logic [3:0] G_CTRL   = 4'h0;
    localparam logic [3:0] G_IEN    = 4'h1;
    localparam logic [3:0] G_ULCLR  = 4'h2;
    localparam logic [3:0] G_ULMASK = 4'h3;
    localparam logic [3:0] G_CRCLR  = 4'h4;
    localparam logic [3:0] G_CRMASK = 4'h5;
    localparam logic [3:0] G_CRSTAT = 4'h6;

    // Field positions
    localparam int ST_LO_BIT    = 17;
    localparam int ST_HI_BIT    = 18;
    localparam int ST_CR_BIT    = 19;
    localparam int ST_SEEN_BIT  = 21;
    localparam int THR_HI_LSB   = 12;
    localparam int UL_HI_LSB    = 16;
    localparam int CM_CYC_BIT   = 30;
    localparam int CM_BARK_BIT  = 31;
    localparam int IE_LO        = 0;
    localparam int IE_HI        = 1;
    localparam int IE_CR        = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              lo;
        logic              hi;
        logic              crit;
        logic              seen;
    } chan_st_t;

endpackage

// File: rtl/tmon_chan.sv
module tmon_chan
    import tmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              samp_vld,
    input  logic [CODE_W-1:0] samp_code,
    input  logic [CODE_W-1:0] thr_lo,
    input  logic [CODE_W-1:0] thr_hi,
    input  logic [CODE_W-1:0] thr_cr,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic              clr_cr,
    output chan_st_t          st_o
);

    chan_st_t st_d, st_q;
    logic take, at_lo, at_hi, at_cr;

    always_comb begin
        take  = gate_en & samp_vld;
        at_lo = $signed(samp_code) <= $signed(thr_lo);
        at_hi = $signed(samp_code) >= $signed(thr_hi);
        at_cr = $signed(samp_code) >= $signed(thr_cr);
        st_d  = st_q;
        if (clr_lo) st_d.lo   = 1'b0;
        if (clr_hi) st_d.hi   = 1'b0;
        if (clr_cr) st_d.crit = 1'b0;
        if (take) begin
            st_d.code = samp_code;
            st_d.seen = 1'b1;
            if (at_lo) st_d.lo   = 1'b1;
            if (at_hi) st_d.hi   = 1'b1;
            if (at_cr) st_d.crit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    AST_GATE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> ($stable(st_q.code) && $stable(st_q.seen))); // R2
    AST_LO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && samp_vld && $signed(samp_code) <= $signed(thr_lo)) |=> st_q.lo); // R3
    AST_HI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && samp_vld && $signed(samp_code) >= $signed(thr_hi)) |=> st_q.hi); // R4
    AST_CR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && samp_vld && $signed(samp_code) >= $signed(thr_cr)) |=> st_q.crit); // R5
    AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hi && !clr_hi) |=> st_q.hi); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hi && !(gate_en && samp_vld)) |=> !st_q.hi); // R7

endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  chan_st_t [NCH-1:0]           st_i,
    input  logic                         bark_st_i,
    output logic                         ctrl_en_o,
    output logic [2:0]                   ien_o,
    output logic [NCH-1:0]               mlo_o,
    output logic [NCH-1:0]               mhi_o,
    output logic [NCH-1:0]               mcr_o,
    output logic                         mbark_o,
    output logic [NCH-1:0][CODE_W-1:0]   tlo_o,
    output logic [NCH-1:0][CODE_W-1:0]   thi_o,
    output logic [NCH-1:0][CODE_W-1:0]   tcr_o,
    output logic [NCH-1:0]               clr_lo_o,
    output logic [NCH-1:0]               clr_hi_o,
    output logic [NCH-1:0]               clr_cr_o,
    output logic                         clr_bark_o
);

    typedef struct packed {
        logic                       en;
        logic [2:0]                 ien;
        logic [NCH-1:0]             mlo;
        logic [NCH-1:0]             mhi;
        logic [NCH-1:0]             mcr;
        logic                       mbark;
        logic                       cyc;
        logic [NCH-1:0][CODE_W-1:0] tlo;
        logic [NCH-1:0][CODE_W-1:0] thi;
        logic [NCH-1:0][CODE_W-1:0] tcr;
    } regs_t;

    regs_t r_d, r_q;
    logic [3:0] rg, idx;

    assign rg  = bus_addr[7:4];
    assign idx = bus_addr[3:0];

    always_comb begin
        r_d        = r_q;
        clr_lo_o   = '0;
        clr_hi_o   = '0;
        clr_cr_o   = '0;
        clr_bark_o = 1'b0;
        if (bus_we) begin
            if (rg == RG_GLOBAL) begin
                case (idx)
                    G_CTRL:   r_d.en  = bus_wdata[0];
                    G_IEN:    r_d.ien = bus_wdata[2:0];
                    G_ULCLR: begin
                        clr_lo_o = bus_wdata[NCH-1:0];
                        clr_hi_o = bus_wdata[UL_HI_LSB +: NCH];
                    end
                    G_ULMASK: begin
                        r_d.mlo = bus_wdata[NCH-1:0];
                        r_d.mhi = bus_wdata[UL_HI_LSB +: NCH];
                    end
                    G_CRCLR: begin
                        clr_cr_o   = bus_wdata[NCH-1:0];
                        clr_bark_o = bus_wdata[CM_BARK_BIT];
                    end
                    G_CRMASK: begin
                        r_d.mcr   = bus_wdata[NCH-1:0];
                        r_d.cyc   = bus_wdata[CM_CYC_BIT];
                        r_d.mbark = bus_wdata[CM_BARK_BIT];
                    end
                    default: ;
                endcase
            end
            for (int i = 0; i < NCH; i++) begin
                if (idx == 4'(i)) begin
                    if (rg == RG_THR) begin
                        r_d.tlo[i] = bus_wdata[CODE_W-1:0];
                        r_d.thi[i] = bus_wdata[THR_HI_LSB +: CODE_W];
                    end
                    if (rg == RG_CRIT) r_d.tcr[i] = bus_wdata[CODE_W-1:0];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rg == RG_GLOBAL) begin
            case (idx)
                G_CTRL: bus_rdata[0]   = r_q.en;
                G_IEN:  bus_rdata[2:0] = r_q.ien;
                G_ULMASK: begin
                    bus_rdata[NCH-1:0]          = r_q.mlo;
                    bus_rdata[UL_HI_LSB +: NCH] = r_q.mhi;
                end
                G_CRMASK: begin
                    bus_rdata[NCH-1:0]   = r_q.mcr;
                    bus_rdata[CM_CYC_BIT]  = r_q.cyc;
                    bus_rdata[CM_BARK_BIT] = r_q.mbark;
                end
                G_CRSTAT: begin
                    for (int i = 0; i < NCH; i++) bus_rdata[i] = st_i[i].crit;
                    bus_rdata[CM_BARK_BIT] = bark_st_i;
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (idx == 4'(i)) begin
                if (rg == RG_STAT) begin
                    bus_rdata[CODE_W-1:0] = st_i[i].code;
                    bus_rdata[ST_LO_BIT]   = st_i[i].lo;
                    bus_rdata[ST_HI_BIT]   = st_i[i].hi;
                    bus_rdata[ST_CR_BIT]   = st_i[i].crit;
                    bus_rdata[ST_SEEN_BIT] = st_i[i].seen;
                end
                if (rg == RG_THR) begin
                    bus_rdata[CODE_W-1:0]          = r_q.tlo[i];
                    bus_rdata[THR_HI_LSB +: CODE_W] = r_q.thi[i];
                end
                if (rg == RG_CRIT) bus_rdata[CODE_W-1:0] = r_q.tcr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.mlo   <= '1;
            r_q.mhi   <= '1;
            r_q.mcr   <= '1;
            r_q.mbark <= 1'b1;
            r_q.cyc   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_en_o = r_q.en;
    assign ien_o     = r_q.ien;
    assign mlo_o     = r_q.mlo;
    assign mhi_o     = r_q.mhi;
    assign mcr_o     = r_q.mcr;
    assign mbark_o   = r_q.mbark;
    assign tlo_o     = r_q.tlo;
    assign thi_o     = r_q.thi;
    assign tcr_o     = r_q.tcr;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == {RG_GLOBAL, G_CTRL}) |=> (ctrl_en_o == $past(bus_wdata[0]))); // R12
    AST_CYC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == {RG_GLOBAL, G_CRMASK}) |=> (r_q.cyc == $past(bus_wdata[CM_CYC_BIT]))); // R11
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(ctrl_en_o) && $stable(ien_o) && $stable(mlo_o))); // R12

endmodule

// File: rtl/tmon_irq.sv
module tmon_irq
    import tmon_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctrl_en,
    input  logic [2:0]     ien,
    input  logic [NCH-1:0] st_lo,
    input  logic [NCH-1:0] st_hi,
    input  logic [NCH-1:0] st_cr,
    input  logic [NCH-1:0] mlo,
    input  logic [NCH-1:0] mhi,
    input  logic [NCH-1:0] mcr,
    input  logic           mbark,
    input  logic           bark_in,
    input  logic           clr_bark,
    output logic           bark_st,
    output logic           irq_ul,
    output logic           irq_cr
);

    typedef struct packed {
        logic bark;
        logic ul;
        logic cr;
    } irq_st_t;

    irq_st_t s_d, s_q;
    logic any_lo, any_hi, any_cr, bark_live;

    always_comb begin
        any_lo    = |(st_lo & ~mlo);
        any_hi    = |(st_hi & ~mhi);
        any_cr    = |(st_cr & ~mcr);
        bark_live = s_q.bark & ~mbark;
        s_d.bark  = (s_q.bark & ~clr_bark) | bark_in;
        s_d.ul    = ctrl_en & ((ien[IE_LO] & any_lo) | (ien[IE_HI] & any_hi));
        s_d.cr    = ctrl_en & ien[IE_CR] & (any_cr | bark_live);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bark_st = s_q.bark;
    assign irq_ul  = s_q.ul;
    assign irq_cr  = s_q.cr;

    AST_UL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !irq_ul); // R8
    AST_CR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mcr) && mbark) |=> !irq_cr); // R9
    AST_BARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        bark_in |=> bark_st); // R10
    AST_BARK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bark_st && !clr_bark) |=> bark_st); // R10

endmodule

// File: rtl/tmon_top.sv
module tmon_top
    import tmon_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        samp_vld,
    input  logic [NCH*CODE_W-1:0] samp_code,
    input  logic                  wd_bark_in,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_ul,
    output logic                  irq_crit
);

    chan_st_t [NCH-1:0]         st;
    logic [NCH-1:0]             st_lo, st_hi, st_cr;
    logic                       ctrl_en, mbark, bark_st, clr_bark;
    logic [2:0]                 ien;
    logic [NCH-1:0]             mlo, mhi, mcr, clr_lo, clr_hi, clr_cr;
    logic [NCH-1:0][CODE_W-1:0] tlo, thi, tcr;

    tmon_regs #(.NCH(NCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .st_i       (st),
        .bark_st_i  (bark_st),
        .ctrl_en_o  (ctrl_en),
        .ien_o      (ien),
        .mlo_o      (mlo),
        .mhi_o      (mhi),
        .mcr_o      (mcr),
        .mbark_o    (mbark),
        .tlo_o      (tlo),
        .thi_o      (thi),
        .tcr_o      (tcr),
        .clr_lo_o   (clr_lo),
        .clr_hi_o   (clr_hi),
        .clr_cr_o   (clr_cr),
        .clr_bark_o (clr_bark)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tmon_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .gate_en   (ctrl_en),
            .samp_vld  (samp_vld[g]),
            .samp_code (samp_code[g*CODE_W +: CODE_W]),
            .thr_lo    (tlo[g]),
            .thr_hi    (thi[g]),
            .thr_cr    (tcr[g]),
            .clr_lo    (clr_lo[g]),
            .clr_hi    (clr_hi[g]),
            .clr_cr    (clr_cr[g]),
            .st_o      (st[g])
        );
        assign st_lo[g] = st[g].lo;
        assign st_hi[g] = st[g].hi;
        assign st_cr[g] = st[g].crit;
    end

    tmon_irq #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .ien      (ien),
        .st_lo    (st_lo),
        .st_hi    (st_hi),
        .st_cr    (st_cr),
        .mlo      (mlo),
        .mhi      (mhi),
        .mcr      (mcr),
        .mbark    (mbark),
        .bark_in  (wd_bark_in),
        .clr_bark (clr_bark),
        .bark_st  (bark_st),
        .irq_ul   (irq_ul),
        .irq_cr   (irq_crit)
    );

endmodule

// File: tb/tmon_top_bench.sv
module tmon_top_bench;

    localparam int NCH = 4;
    localparam int CW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    samp_vld = '0;
    logic [NCH*CW-1:0] samp_code = '0;
    logic              wd_bark_in = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_ul, irq_crit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int lo_t [NCH];
    int hi_t [NCH];
    int cr_t [NCH];

    always #5 clk = ~clk;

    tmon_top #(.NCH(NCH)) u_tmon_top (
        .clk (clk), .rst_n (rst_n), .samp_vld (samp_vld), .samp_code (samp_code),
        .wd_bark_in (wd_bark_in), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_ul (irq_ul), .irq_crit (irq_crit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic sample(input int ch, input logic [11:0] code);
        @(negedge clk);
        samp_vld[ch] = 1'b1;
        samp_code[ch*CW +: CW] = code;
        @(negedge clk);
        samp_vld = '0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic clear_all();
        wr(8'h02, 32'hFFFF_FFFF); wr(8'h02, 32'h0);
        wr(8'h04, 32'h0000_000F); wr(8'h04, 32'h0);
    endtask

    function automatic logic [31:0] thr_word(input int lo, input int hi);
        return 32'(((hi & 'hFFF) << 12) | (lo & 'hFFF));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NCH; i++) begin
            lo_t[i] = -50 + 7 * i;
            hi_t[i] = 100 + 7 * i;
            cr_t[i] = 200 + 7 * i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h01, v); chk("R1 ien", v, 32'h0);
        rd(8'h03, v); chk("R1 ulmask", v, 32'h000F_000F);
        rd(8'h05, v); chk("R1 crmask", v, 32'hC000_000F);
        rd(8'h20, v); chk("R1 thr", v, 32'h0);
        rd(8'h33, v); chk("R1 crit", v, 32'h0);
        rd(8'h12, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", {30'h0, irq_ul, irq_crit}, 32'h0);

        // R2 ignored while disabled
        sample(0, 12'h123);
        rd(8'h10, v); chk("R2 gated", v, 32'h0);

        for (int i = 0; i < NCH; i++) begin
            wr(8'(8'h20 + i), thr_word(lo_t[i], hi_t[i]));
            wr(8'(8'h30 + i), 32'(cr_t[i] & 'hFFF));
        end
        rd(8'h21, v); chk("R12 thr readback", v, thr_word(lo_t[1], hi_t[1]));
        rd(8'h32, v); chk("R12 crit readback", v, 32'(cr_t[2]));
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R12 ctrl readback", v, 32'h1);

        // R2..R5 exhaustive code sweep
        for (int c = 0; c < 4096; c++) begin
            int ch;
            int sc;
            logic [31:0] e;
            ch = c % NCH;
            sc = (c >= 2048) ? c - 4096 : c;
            e = 32'(c) | (32'h1 << 21);
            if (sc <= lo_t[ch]) e |= 32'h1 << 17;
            if (sc >= hi_t[ch]) e |= 32'h1 << 18;
            if (sc >= cr_t[ch]) e |= 32'h1 << 19;
            sample(ch, 12'(c));
            rd(8'(8'h10 + ch), v);
            chk("R2/R3/R4/R5 sweep", v, e);
            if (v[19:17] != 3'b000) clear_all();
        end

        // R5 critical status mirror
        sample(2, 12'h7FF);
        rd(8'h06, v); chk("R5 crstat", v, 32'h0000_0004);
        clear_all();

        // R6 sticky and pulse clear
        sample(1, 12'h7FF);
        rd(8'h11, v); chk("R6 set", v, 32'h002C_07FF);
        sample(1, 12'h000);
        rd(8'h11, v); chk("R6 sticky", v, 32'h002C_0000);
        wr(8'h02, 32'h0);
        rd(8'h11, v); chk("R6 zero write", v, 32'h002C_0000);
        wr(8'h02, 32'h0002_0000);
        rd(8'h11, v); chk("R6 high clear", v, 32'h0028_0000);
        wr(8'h04, 32'h0000_0002);
        rd(8'h11, v); chk("R6 crit clear", v, 32'h0020_0000);

        // R7 set and clear in one cycle
        @(negedge clk);
        samp_vld[2] = 1'b1; samp_code[2*CW +: CW] = 12'h7FF;
        bus_we = 1'b1; bus_addr = 8'h02; bus_wdata = 32'h0004_0000;
        @(negedge clk);
        samp_vld = '0; bus_we = 1'b0;
        rd(8'h12, v); chk("R7 set wins", v, 32'h002C_07FF);
        @(negedge clk);
        samp_vld[2] = 1'b1; samp_code[2*CW +: CW] = 12'h000;
        bus_we = 1'b1; bus_addr = 8'h02; bus_wdata = 32'h0004_0000;
        @(negedge clk);
        samp_vld = '0; bus_we = 1'b0;
        rd(8'h12, v); chk("R7 clear wins", v, 32'h0028_0000);
        clear_all();

        // R8 low/high interrupt
        wr(8'h01, 32'h7);
        sample(3, 12'h800);
        settle(); chk("R8 masked", {31'h0, irq_ul}, 32'h0);
        wr(8'h03, 32'h0000_000F);
        settle(); chk("R8 upper unmask only", {31'h0, irq_ul}, 32'h0);
        wr(8'h03, 32'h000F_0007);
        settle(); chk("R8 lower unmask", {31'h0, irq_ul}, 32'h1);
        wr(8'h01, 32'h6);
        settle(); chk("R8 enable off", {31'h0, irq_ul}, 32'h0);
        wr(8'h01, 32'h7);
        wr(8'h00, 32'h0);
        settle(); chk("R8 global off", {31'h0, irq_ul}, 32'h0);
        wr(8'h00, 32'h1);
        settle(); chk("R8 global on", {31'h0, irq_ul}, 32'h1);
        wr(8'h02, 32'h0000_0008); wr(8'h02, 32'h0);
        settle(); chk("R8 cleared", {31'h0, irq_ul}, 32'h0);
        sample(0, 12'h07F);
        wr(8'h03, 32'h000E_000F);
        settle(); chk("R8 upper source", {31'h0, irq_ul}, 32'h1);
        clear_all();

        // R9 critical interrupt
        sample(0, 12'h7FF);
        settle(); chk("R9 masked", {31'h0, irq_crit}, 32'h0);
        wr(8'h05, 32'hC000_000E);
        settle(); chk("R9 unmasked", {31'h0, irq_crit}, 32'h1);
        wr(8'h01, 32'h3);
        settle(); chk("R9 enable off", {31'h0, irq_crit}, 32'h0);
        wr(8'h01, 32'h7);
        wr(8'h04, 32'h0000_0001); wr(8'h04, 32'h0);
        settle(); chk("R9 cleared", {31'h0, irq_crit}, 32'h0);

        // R10 bark
        @(negedge clk); wd_bark_in = 1'b1;
        @(negedge clk); wd_bark_in = 1'b0;
        rd(8'h06, v); chk("R10 bark status", v, 32'h8000_0000);
        settle(); chk("R10 bark masked", {31'h0, irq_crit}, 32'h0);
        wr(8'h05, 32'h4000_000F);
        settle(); chk("R10 bark irq", {31'h0, irq_crit}, 32'h1);
        @(negedge clk);
        wd_bark_in = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h8000_0000;
        @(negedge clk);
        wd_bark_in = 1'b0; bus_we = 1'b0;
        rd(8'h06, v); chk("R10 set wins", v, 32'h8000_0000);
        wr(8'h04, 32'h8000_0000); wr(8'h04, 32'h0);
        rd(8'h06, v); chk("R10 cleared", v, 32'h0);
        settle(); chk("R10 irq low", {31'h0, irq_crit}, 32'h0);

        // R11 stored cycle-monitor bit
        wr(8'h05, 32'h8000_000F);
        rd(8'h05, v); chk("R11 bit30 low", v, 32'h8000_000F);
        wr(8'h05, 32'hC000_0005);
        rd(8'h05, v); chk("R11 bit30 high", v, 32'hC000_0005);
        wr(8'h03, 32'h0005_000A);
        rd(8'h03, v); chk("R12 ulmask readback", v, 32'h0005_000A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule